// File: doc/BRIEF.md
# Array Multiply-Add Engine

The engine applies the affine map y = a*x + b + c to each word of a small array that sits in a synchronous single-port RAM. Each result goes to a second RAM. The coefficient a and the two offsets b and c arrive as signed 8-bit values on their own input pins. A start pulse launches a pass over the array. A one-cycle done pulse reports that the last result has been stored.

A four-state controller drives the pass. The idle state captures the coefficient and folds both offsets into one registered sum, so the offsets are added once per pass and not once per element. The engine then repeats a three-cycle body for each element. In the first cycle it issues the read. In the second cycle the RAM returns the word after its one-cycle latency and the engine captures it. In the third cycle it writes the result. Both RAMs are driven directly by the engine, with no buffering in between.

Top module: `affine_array_engine`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, src_ce, dst_ce, dst_we and done are all 0.
- R2: A pass begins only when start is 1 at a clock edge while the engine is idle. A start seen during a pass has no effect on the writes or on the timing of done.
- R3: In the cycle after start is sampled, src_ce is 1 with src_addr = 0. The read strobe then repeats every third cycle with src_addr = 1 and then 2, and it is high for one cycle each time.
- R4: Two cycles after each read strobe, dst_ce and dst_we are both 1 for one cycle, with dst_addr equal to the address of that read. dst_addr already holds this value in the cycle before the write.
- R5: dst_wdata equals sx(a)*x + sx(b) + sx(c) modulo 2^32. Here x is the 32-bit word read from the source RAM and sx is sign extension from 8 to 32 bits.
- R6: a, b and c are sampled only at the start edge. Changing them during a pass does not change that pass's results.
- R7: Each pass makes exactly three writes, to addresses 0, 1 and 2 in that order. dst_we is never 1 outside a pass.
- R8: done is 1 for exactly one cycle, in the cycle after the third write. This is the tenth cycle after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches a pass when the engine is idle |
| coef_a | input | 8 | Signed multiplier coefficient |
| ofs_b | input | 8 | Signed first offset |
| ofs_c | input | 8 | Signed second offset |
| src_addr | output | 2 | Source RAM word address |
| src_ce | output | 1 | Source RAM read enable |
| src_rdata | input | 32 | Source RAM read data, one cycle after src_ce |
| dst_addr | output | 2 | Destination RAM word address |
| dst_ce | output | 1 | Destination RAM enable |
| dst_we | output | 1 | Destination RAM write enable |
| dst_wdata | output | 32 | Result word to store |
| done | output | 1 | One-cycle pulse at the end of a pass |

## Verification
The assertions check the following on every cycle:
- each read strobe lasts one cycle and is followed two cycles later by a write to the same address;
- every write carries its chip enable and holds a stable address;
- write pulses never stretch;
- done follows only a write.

Other behaviours can only be shown by the bench's scenarios. These are the arithmetic with wrap-around at the signed extremes, the fact that the parameters are captured only at the start edge, the rejection of a start pulse during a pass, and the exact ten-cycle distance from start to done.

// File: rtl/affine_pkg.sv
package affine_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_LOAD = 2'd2,
    ST_WRIT = 2'd3
  } eng_state_t;
endpackage

// File: rtl/affine_ctrl.sv
module affine_ctrl #(
  parameter int DEPTH  = 3,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              ld_params,
  output logic              rd_en,
  output logic              cap_en,
  output logic              wr_en,
  output logic [ADDR_W-1:0] index,
  output logic              done
);
  import affine_pkg::*;

  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(DEPTH - 1);

  eng_state_t        state_q, state_d;
  logic [ADDR_W-1:0] idx_q, idx_d;
  logic              idx_en;
  logic              done_q;
  logic              last;

  assign last = (idx_q == LAST_IDX);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_READ;
      ST_READ: state_d = ST_LOAD;
      ST_LOAD: state_d = ST_WRIT;
      ST_WRIT: state_d = last ? ST_IDLE : ST_READ;
      default: state_d = ST_IDLE;
    endcase
  end

  assign ld_params = (state_q == ST_IDLE) && start;
  assign rd_en     = (state_q == ST_READ);
  assign cap_en    = (state_q == ST_LOAD);
  assign wr_en     = (state_q == ST_WRIT);

  always_comb begin
    idx_en = ld_params | wr_en;
    if (ld_params)   idx_d = '0;
    else if (last)   idx_d = '0;
    else             idx_d = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= wr_en & last;
  end

  assign index = idx_q;
  assign done  = done_q;
endmodule

// File: rtl/affine_dp.sv
module affine_dp #(
  parameter int DATA_W = 32,
  parameter int COEF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_params,
  input  logic              cap_en,
  input  logic [COEF_W-1:0] coef_a,
  input  logic [COEF_W-1:0] ofs_b,
  input  logic [COEF_W-1:0] ofs_c,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] result
);
  localparam int EXT_W = DATA_W - COEF_W;

  logic [DATA_W-1:0] a_ext, b_ext, c_ext;
  logic [DATA_W-1:0] a_q, sum_q, x_q;
  logic [DATA_W-1:0] prod;

  assign a_ext = {{EXT_W{coef_a[COEF_W-1]}}, coef_a};
  assign b_ext = {{EXT_W{ofs_b[COEF_W-1]}}, ofs_b};
  assign c_ext = {{EXT_W{ofs_c[COEF_W-1]}}, ofs_c};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      sum_q <= '0;
    end else if (ld_params) begin
      a_q   <= a_ext;
      sum_q <= b_ext + c_ext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      x_q <= '0;
    else if (cap_en) x_q <= rdata;
  end

  assign prod   = a_q * x_q;
  assign result = prod + sum_q;
endmodule

// File: rtl/affine_array_engine.sv
module affine_array_engine #(
  parameter int DATA_W = 32,
  parameter int COEF_W = 8,
  parameter int DEPTH  = 3,
  parameter int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [COEF_W-1:0] coef_a,
  input  logic [COEF_W-1:0] ofs_b,
  input  logic [COEF_W-1:0] ofs_c,
  output logic [ADDR_W-1:0] src_addr,
  output logic              src_ce,
  input  logic [DATA_W-1:0] src_rdata,
  output logic [ADDR_W-1:0] dst_addr,
  output logic              dst_ce,
  output logic              dst_we,
  output logic [DATA_W-1:0] dst_wdata,
  output logic              done
);
  logic              ld_params, rd_en, cap_en, wr_en;
  logic [ADDR_W-1:0] index;

  affine_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .ld_params (ld_params),
    .rd_en     (rd_en),
    .cap_en    (cap_en),
    .wr_en     (wr_en),
    .index     (index),
    .done      (done)
  );

  affine_dp #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_params (ld_params),
    .cap_en    (cap_en),
    .coef_a    (coef_a),
    .ofs_b     (ofs_b),
    .ofs_c     (ofs_c),
    .rdata     (src_rdata),
    .result    (dst_wdata)
  );

  assign src_addr = index;
  assign src_ce   = rd_en;
  assign dst_addr = index;
  assign dst_ce   = wr_en;
  assign dst_we   = wr_en;
endmodule

// File: rtl/affine_array_engine_chk.sv
module affine_array_engine_chk #(
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] src_addr,
  input logic              src_ce,
  input logic [ADDR_W-1:0] dst_addr,
  input logic              dst_ce,
  input logic              dst_we,
  input logic              done
);
  // R3
  rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_ce |=> !src_ce);

  // R4
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_ce |-> ##2 (dst_we && dst_addr == $past(src_addr, 2)));

  // R4
  we_has_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dst_we |-> dst_ce);

  // R4
  wr_addr_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dst_we |-> $stable(dst_addr));

  // R7
  wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dst_we |=> !dst_we);

  // R8
  done_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(dst_we));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind affine_array_engine affine_array_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .src_addr (src_addr),
  .src_ce   (src_ce),
  .dst_addr (dst_addr),
  .dst_ce   (dst_ce),
  .dst_we   (dst_we),
  .done     (done)
);

// File: tb/affine_array_engine_tb.sv
module affine_array_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [7:0]  coef_a, ofs_b, ofs_c;
  logic [1:0]  src_addr, dst_addr;
  logic        src_ce, dst_ce, dst_we, done;
  logic [31:0] src_rdata, dst_wdata;
  logic [31:0] src_mem [4];

  int checks = 0;
  int fails  = 0;
  int writes = 0;
  logic [33:0] expq [$];

  always #10 clk = ~clk;

  affine_array_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .coef_a(coef_a), .ofs_b(ofs_b), .ofs_c(ofs_c),
    .src_addr(src_addr), .src_ce(src_ce), .src_rdata(src_rdata),
    .dst_addr(dst_addr), .dst_ce(dst_ce), .dst_we(dst_we),
    .dst_wdata(dst_wdata), .done(done)
  );

  always @(posedge clk) if (src_ce) src_rdata <= src_mem[src_addr];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && dst_we) begin
      logic [33:0] e;
      writes++;
      if (expq.size() == 0) begin
        check("R7 unexpected write", 32'(dst_addr), 32'hffff_ffff);
      end else begin
        e = expq.pop_front();
        check("R4 dst_addr", 32'(dst_addr), 32'(e[33:32]));
        check("R4 dst_ce", 32'(dst_ce), 32'd1);
        check("R5 dst_wdata", dst_wdata, e[31:0]);
      end
    end
  end

  // driver: loads source RAM, pushes expected writes, runs one pass
  task automatic run_pass(input logic signed [7:0] a, input logic signed [7:0] b,
                          input logic signed [7:0] c, input logic [31:0] d0,
                          input logic [31:0] d1, input logic [31:0] d2,
                          input bit disturb);
    int w0;
    src_mem[0] = d0; src_mem[1] = d1; src_mem[2] = d2; src_mem[3] = '0;
    for (int i = 0; i < 3; i++) begin
      int x, y;
      x = int'(src_mem[i]);
      y = int'(a) * x + int'(b) + int'(c);
      expq.push_back({2'(i), 32'(y)});
    end
    w0 = writes;
    @(negedge clk);
    coef_a = a; ofs_b = b; ofs_c = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R3: first read in the cycle after start is sampled
    check("R3 src_ce first", 32'(src_ce), 32'd1);
    check("R3 src_addr first", 32'(src_addr), 32'd0);
    if (disturb) begin
      coef_a = 8'h55; ofs_b = 8'h11; ofs_c = 8'h22;  // R6
    end
    for (int n = 2; n <= 11; n++) begin
      @(negedge clk);
      if (disturb && n == 3) start = 1'b1;             // R2 start while busy
      if (disturb && n == 4) start = 1'b0;
      if (n == 4 || n == 7) begin
        check("R3 src_ce repeat", 32'(src_ce), 32'd1);
        check("R3 src_addr repeat", 32'(src_addr), 32'((n - 1) / 3));
      end
      check("R8 done timing", 32'(done), (n == 10) ? 32'd1 : 32'd0);
    end
    check("R7 write count", 32'(writes - w0), 32'd3);
    check("R7 queue drained", 32'(expq.size()), 32'd0);
    check("R2 idle after pass", 32'(src_ce), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; coef_a = '0; ofs_b = '0; ofs_c = '0;
    for (int i = 0; i < 4; i++) src_mem[i] = '0;
    repeat (3) @(negedge clk);
    check("R1 src_ce in reset", 32'(src_ce), 32'd0);
    check("R1 dst_we in reset", 32'(dst_we), 32'd0);
    check("R1 done in reset", 32'(done), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 src_ce after reset", 32'(src_ce), 32'd0);
    check("R1 dst_ce after reset", 32'(dst_ce), 32'd0);
    check("R1 done after reset", 32'(done), 32'd0);

    run_pass(8'sd3, 8'sd5, -8'sd2, 32'd10, 32'd0, -32'sd7, 1'b0);
    run_pass(-8'sd1, 8'sd0, 8'sd0, 32'd1, 32'd2, 32'd3, 1'b0);
    run_pass(-8'sd128, 8'sd127, 8'sd127, 32'h7fff_ffff, 32'h8000_0000, 32'hffff_ffff, 1'b0);
    run_pass(8'sd7, -8'sd100, 8'sd50, 32'd1000, 32'h1234_5678, -32'sd1, 1'b1);

    // R7: no writes while idle without start
    begin
      int w0;
      w0 = writes;
      repeat (12) @(negedge clk);
      check("R7 no idle writes", 32'(writes - w0), 32'd0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule